// File: doc/BRIEF.md
# Fault-Hardened Flip-Flop Register File

This block is the integer register file of a small processor core: thirty-two registers of 32 bits, two combinational read ports and one write port. Register zero is hardwired to zero. A write takes effect on the rising clock edge. The data read on a port changes in the same cycle as that port's address.

With the hardening parameter set, each read address and the write request are first decoded into one-hot select vectors. The read data comes from an AND-OR multiplexer driven by the decoded vector, not from a binary index. A checker watches every select vector. If a vector is not a legal one-hot code, for example because a glitch was injected, the checker flags it. The flags are merged into a registered major alert that stays set until reset. The block never masks or repairs a bad select; it only raises the alert so the system can act on it.

With the hardening parameter cleared, the reads use plain indexing and the alert output is held low. Read and write behaviour is otherwise the same. Upsets on the binary address lines before decoding are left to other protection.

Top module: `regfile_onehot`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 on both ports and the alert output is 0.
- R2: When the write enable is 1 at a rising clock edge, the addressed register (index 1 to 31) takes the write data, and reads return it from the next cycle on.
- R3: When the write enable is 0 at a rising edge, no register changes.
- R4: Register index 0 always reads 0, and writes to it are discarded.
- R5: Each of the two read ports returns the contents of its own addressed register combinationally, independent of the other port.
- R6: If the port A select vector does not have exactly one bit set, the alert output is 1 after the next rising clock edge.
- R7: If the port B select vector does not have exactly one bit set, the alert output is 1 after the next rising clock edge.
- R8: If the write select vector has any bit set while write enable is 0, or has more than one bit set, the alert output is 1 after the next rising clock edge.
- R9: Once set, the alert output stays 1 until reset, even after the faulty vector returns to a legal value.
- R10: A faulty select is not corrected. Read data is the bitwise OR of all selected registers, which is 0 when no bit is selected. Every register selected by the write vector is written.
- R11: With the hardening parameter cleared, the alert output stays 0 and the reads return the same values as the hardened variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| raddr_a_i | input | 5 | Read address, port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 5 | Read address, port B |
| rdata_b_o | output | 32 | Read data, port B |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write address |
| wdata_i | input | 32 | Write data |
| alert_major_o | output | 1 | Sticky major alert for a bad select vector |

## Verification
Read data is combinational, so the bench sets the addresses in the low phase of the clock and samples one time unit later, with no edge in between. A write shows up on the ports just after the next rising edge, and the bench checks it at the following falling edge. The alert passes through one register. When a select vector is forced to a bad value, the bench checks that the alert is still 0 in the same low phase and is 1 at the next falling edge. This pins the alert to exactly one cycle of latency. The sweep then checks that the alert stays 1 over several more cycles after the force is released.

// File: rtl/regfile_pkg.sv
// Package: regfile_pkg
// Shared default sizes for the hardened register file and its helpers.
package regfile_pkg;
    parameter int unsigned RF_NUM_REGS = 32;
    parameter int unsigned RF_DATA_W   = 32;
endpackage

// File: rtl/rf_oh_decoder.sv
// Module: rf_oh_decoder
// Turns a binary index into a one-hot vector, gated by an enable.
// Assumes Width <= 2**AddrW. With en_i low the output is all zeros.
module rf_oh_decoder #(
    parameter int unsigned Width = 32,
    parameter int unsigned AddrW = $clog2(Width)
) (
    input  logic             en_i,
    input  logic [AddrW-1:0] addr_i,
    output logic [Width-1:0] oh_o
);
    // Compare the index against every position.
    always_comb begin
        for (int k = 0; k < Width; k++) begin
            oh_o[k] = en_i && (addr_i == AddrW'(k));
        end
    end
endmodule

// File: rtl/rf_oh_mux.sv
// Module: rf_oh_mux
// AND-OR multiplexer. It ORs together every word whose select bit is set.
// Assumes nothing about the select vector: an illegal select gives the OR of
// the selected words (0 when none is selected). It never repairs the select.
module rf_oh_mux #(
    parameter int unsigned Width = 32,
    parameter int unsigned DataW = 32
) (
    input  logic [Width-1:0]            sel_i,
    input  logic [Width-1:0][DataW-1:0] words_i,
    output logic [DataW-1:0]            data_o
);
    // Mask each word with its select bit and accumulate.
    always_comb begin
        data_o = '0;
        for (int k = 0; k < Width; k++) begin
            data_o = data_o | (words_i[k] & {DataW{sel_i[k]}});
        end
    end
endmodule

// File: rtl/rf_oh_checker.sv
// Module: rf_oh_checker
// Flags a select vector that is not a legal code. With expect_i high, a legal
// vector has exactly one bit set. With expect_i low, it is all zeros.
// The flag is combinational. The clock and reset are used only by the
// assertion below.
module rf_oh_checker #(
    parameter int unsigned Width = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             expect_i,
    input  logic [Width-1:0] vec_i,
    output logic             err_o
);
    logic seen;
    logic multi;

    // Scan the vector: note whether any bit is set and whether a second one follows.
    always_comb begin
        seen  = 1'b0;
        multi = 1'b0;
        for (int k = 0; k < Width; k++) begin
            multi = multi | (seen & vec_i[k]);
            seen  = seen | vec_i[k];
        end
        err_o = multi | (expect_i ? ~seen : seen);
    end

    // R6 R7 R8: the flag agrees with the population count of the vector.
    assert_err_tracks_popcount_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o == (expect_i ? ($countones(vec_i) != 1) : ($countones(vec_i) != 0)));
endmodule

// File: rtl/regfile_onehot.sv
// Module: regfile_onehot
// Register file with two combinational read ports and one write port.
// Index 0 reads as zero. With Secure=1 the read and write selects are one-hot
// vectors, each checked, and any violation sets a sticky major alert at the
// next clock edge. With Secure=0 the reads use binary indexing and the alert
// is held low. Assumes NumRegs is a power of two.
module regfile_onehot
    import regfile_pkg::*;
#(
    parameter int unsigned NumRegs = RF_NUM_REGS,
    parameter int unsigned DataW   = RF_DATA_W,
    parameter bit          Secure  = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [$clog2(NumRegs)-1:0] raddr_a_i,
    output logic [DataW-1:0]           rdata_a_o,
    input  logic [$clog2(NumRegs)-1:0] raddr_b_i,
    output logic [DataW-1:0]           rdata_b_o,
    input  logic                       we_i,
    input  logic [$clog2(NumRegs)-1:0] waddr_i,
    input  logic [DataW-1:0]           wdata_i,
    output logic                       alert_major_o
);
    localparam int unsigned AddrW = $clog2(NumRegs);

    logic [DataW-1:0]              rf_q [1:NumRegs-1];
    logic [NumRegs-1:0][DataW-1:0] words;
    logic [NumRegs-1:0]            wen_oh;
    logic [NumRegs-1:0]            sel_a_oh;
    logic [NumRegs-1:0]            sel_b_oh;

    // Write select: one-hot, all zeros when no write is requested.
    rf_oh_decoder #(.Width(NumRegs), .AddrW(AddrW)) u_dec_w (
        .en_i  (we_i),
        .addr_i(waddr_i),
        .oh_o  (wen_oh)
    );

    // Storage: every register flagged by the write select takes the data.
    always_ff @(posedge clk_i) begin
        for (int k = 1; k < NumRegs; k++) begin
            if (!rst_ni) begin
                rf_q[k] <= '0;
            end else if (wen_oh[k]) begin
                rf_q[k] <= wdata_i;
            end
        end
    end

    // Read view: word 0 is a constant zero, the rest come from storage.
    always_comb begin
        words[0] = '0;
        for (int k = 1; k < NumRegs; k++) begin
            words[k] = rf_q[k];
        end
    end

    for (genvar g = 1; g < NumRegs; g++) begin : g_wr_chk
        // R2 R10: a selected register holds the data written at the edge.
        assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wen_oh[g] |=> rf_q[g] == $past(wdata_i));
        // R3: an unselected register keeps its value.
        assert_hold_unselected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !wen_oh[g] |=> $stable(rf_q[g]));
    end

    if (Secure) begin : g_secure
        logic err_a;
        logic err_b;
        logic err_w;
        logic alert_q;

        // Port A and B selects come from decoders that are always enabled.
        rf_oh_decoder #(.Width(NumRegs), .AddrW(AddrW)) u_dec_a (
            .en_i  (1'b1),
            .addr_i(raddr_a_i),
            .oh_o  (sel_a_oh)
        );
        rf_oh_decoder #(.Width(NumRegs), .AddrW(AddrW)) u_dec_b (
            .en_i  (1'b1),
            .addr_i(raddr_b_i),
            .oh_o  (sel_b_oh)
        );

        rf_oh_mux #(.Width(NumRegs), .DataW(DataW)) u_mux_a (
            .sel_i  (sel_a_oh),
            .words_i(words),
            .data_o (rdata_a_o)
        );
        rf_oh_mux #(.Width(NumRegs), .DataW(DataW)) u_mux_b (
            .sel_i  (sel_b_oh),
            .words_i(words),
            .data_o (rdata_b_o)
        );

        rf_oh_checker #(.Width(NumRegs)) u_chk_a (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .expect_i(1'b1),
            .vec_i   (sel_a_oh),
            .err_o   (err_a)
        );
        rf_oh_checker #(.Width(NumRegs)) u_chk_b (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .expect_i(1'b1),
            .vec_i   (sel_b_oh),
            .err_o   (err_b)
        );
        rf_oh_checker #(.Width(NumRegs)) u_chk_w (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .expect_i(we_i),
            .vec_i   (wen_oh),
            .err_o   (err_w)
        );

        // Sticky alert: set by any checker flag, cleared only by reset.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                alert_q <= 1'b0;
            end else if (err_a || err_b || err_w) begin
                alert_q <= 1'b1;
            end
        end
        assign alert_major_o = alert_q;

        // R6 R7 R8: a flag at an edge shows up on the alert after that edge.
        assert_flag_raises_alert_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (err_a || err_b || err_w) |=> alert_major_o);
        // R9: the alert never drops while reset is released.
        assert_alert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            alert_major_o |=> alert_major_o);
        // R4: with a legal select, address 0 reads zero.
        assert_zero_reg_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!err_a && raddr_a_i == '0) |-> rdata_a_o == '0);
    end else begin : g_plain
        assign sel_a_oh      = '0;
        assign sel_b_oh      = '0;
        assign rdata_a_o     = words[raddr_a_i];
        assign rdata_b_o     = words[raddr_b_i];
        assign alert_major_o = 1'b0;
    end

    // R1: the alert is low in the cycle after a reset edge.
    assert_reset_clears_alert_R1: assert property (@(posedge clk_i)
        !rst_ni |=> !alert_major_o);
endmodule

// File: tb/regfile_onehot_bench.sv
module regfile_onehot_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] raddr_a = '0;
    logic [AW-1:0] raddr_b = '0;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata_a, rdata_b, rdata_a_p, rdata_b_p;
    logic          alert, alert_p;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    regfile_onehot #(.NumRegs(N), .DataW(DW), .Secure(1'b1)) u_regfile_onehot (
        .clk_i(clk), .rst_ni(rst_n),
        .raddr_a_i(raddr_a), .rdata_a_o(rdata_a),
        .raddr_b_i(raddr_b), .rdata_b_o(rdata_b),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .alert_major_o(alert)
    );

    regfile_onehot #(.NumRegs(N), .DataW(DW), .Secure(1'b0)) u_regfile_onehot_plain (
        .clk_i(clk), .rst_ni(rst_n),
        .raddr_a_i(raddr_a), .rdata_a_o(rdata_a_p),
        .raddr_b_i(raddr_b), .rdata_b_o(rdata_b_p),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .alert_major_o(alert_p)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return (i == 0) ? '0 : ((DW'(i) * 32'h9E3779B9) ^ 32'h5A5A0F0F);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        we    = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input int i, input logic [DW-1:0] d);
        we    = 1'b1;
        waddr = AW'(i);
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic fill();
        for (int i = 0; i < N; i++) write_reg(i, (i == 0) ? 32'hFFFF_FFFF : pat(i));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: every register reads zero, alerts low
        for (int i = 0; i < N; i++) begin
            raddr_a = AW'(i);
            raddr_b = AW'(N - 1 - i);
            #1;
            chk("R1 port A after reset", rdata_a, '0);
            chk("R1 port B after reset", rdata_b, '0);
        end
        chk("R1 alert after reset", DW'(alert), '0);

        // R2 R4: write all registers, x0 write of all-ones must be discarded
        fill();
        // R5 R2 R4 R11: sweep every address pair on both ports
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                raddr_a = AW'(a);
                raddr_b = AW'(b);
                #1;
                chk("R5 port A", rdata_a, pat(a));
                chk("R5 port B", rdata_b, pat(b));
                chk("R11 plain port A", rdata_a_p, pat(a));
                chk("R11 plain port B", rdata_b_p, pat(b));
            end
        end
        raddr_a = '0;
        #1;
        chk("R4 x0 reads zero after write", rdata_a, '0);

        // R3: no write with enable low
        @(negedge clk);
        we = 1'b0; waddr = 5'd7; wdata = 32'hFFFF_0000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        raddr_a = 5'd7;
        #1;
        chk("R3 no write when enable low", rdata_a, pat(7));
        chk("R11 plain alert low", DW'(alert_p), '0);
        chk("R6 no alert on legal traffic", DW'(alert), '0);

        // R10 R6: port A select with two bits
        @(negedge clk);
        raddr_a = 5'd3;
        force u_regfile_onehot.sel_a_oh = (32'h1 << 3) | (32'h1 << 9);
        #1;
        chk("R10 port A reads OR of two", rdata_a, pat(3) | pat(9));
        chk("R6 alert not yet set", DW'(alert), '0);
        @(negedge clk);
        #1;
        chk("R6 alert after one edge", DW'(alert), 32'd1);
        release u_regfile_onehot.sel_a_oh;
        for (int c = 0; c < 4; c++) @(negedge clk);
        #1;
        chk("R9 alert sticky", DW'(alert), 32'd1);
        chk("R11 plain alert low", DW'(alert_p), '0);

        do_reset();
        #1;
        chk("R1 alert cleared by reset", DW'(alert), '0);
        fill();

        // R10 R7: port B select with no bits
        raddr_b = 5'd12;
        force u_regfile_onehot.sel_b_oh = '0;
        #1;
        chk("R10 port B empty select reads zero", rdata_b, '0);
        chk("R7 alert not yet set", DW'(alert), '0);
        @(negedge clk);
        #1;
        chk("R7 alert after one edge", DW'(alert), 32'd1);
        release u_regfile_onehot.sel_b_oh;
        #1;
        chk("R5 port B after release", rdata_b, pat(12));

        do_reset();
        fill();
        // R6: port A select with a single wrong bit set is still legal one-hot, no alert
        raddr_a = 5'd2;
        force u_regfile_onehot.sel_a_oh = 32'h1 << 20;
        #1;
        chk("R10 port A follows the select", rdata_a, pat(20));
        @(negedge clk);
        #1;
        chk("R6 single-bit flip to another legal code", DW'(alert), '0);
        release u_regfile_onehot.sel_a_oh;

        // R8 R10: write select glitch with enable low
        @(negedge clk);
        we = 1'b0; wdata = 32'hC0FF_EE00;
        force u_regfile_onehot.wen_oh = (32'h1 << 4) | (32'h1 << 5);
        #1;
        chk("R8 alert not yet set", DW'(alert), '0);
        @(negedge clk);
        release u_regfile_onehot.wen_oh;
        #1;
        chk("R8 alert after one edge", DW'(alert), 32'd1);
        raddr_a = 5'd4; raddr_b = 5'd5;
        #1;
        chk("R10 glitched write reaches reg 4", rdata_a, 32'hC0FF_EE00);
        chk("R10 glitched write reaches reg 5", rdata_b, 32'hC0FF_EE00);

        // R8: extra bit on a real write
        do_reset();
        fill();
        @(negedge clk);
        we = 1'b1; waddr = 5'd8; wdata = 32'h1234_5678;
        force u_regfile_onehot.wen_oh = (32'h1 << 8) | (32'h1 << 30);
        @(negedge clk);
        release u_regfile_onehot.wen_oh;
        we = 1'b0;
        #1;
        chk("R8 alert on two-bit write select", DW'(alert), 32'd1);
        raddr_a = 5'd30;
        #1;
        chk("R10 second register also written", rdata_a, 32'h1234_5678);
        chk("R11 plain alert low at end", DW'(alert_p), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule